// File: doc/BRIEF.md
# Expansion-Bus Configuration Responder

This block is the plug-and-play configuration front end of an expansion card sitting on a 24-bit host address bus. While the card is still unconfigured and its chain-enable input is active, it answers reads in a fixed 64 KB configuration page. In that page it shows sixteen identification bytes. Each byte is split into two nibbles, and every nibble is driven on data bits [7:4]. Byte 0 is shown as-is. Every other byte is shown inverted, so a host that reads unprogrammed storage as all ones sees zeros.

The host ends configuration in one of two ways. It can write a byte to the base-address offset, which places the card's 64 KB window at that address. It can instead write to the shut-up offset, which retires the card without mapping it. In both cases the card leaves the configuration page and raises its chain-enable output so that the next card in the chain can be configured. Once the card is mapped, it flags every host access whose upper address byte equals the assigned base. Decoding the card's own registers inside that window is left to logic outside this block.

Top module: `acfg_responder`

## Requirements
- R1: A synchronous active-low reset returns the card to the unconfigured state. After reset cfg_chain_out is 0, rd_data is 0xFF, and win_hit stays 0 for any access.
- R2: A configuration read is a read with host_rd high, host_addr[23:16] equal to CFG_PAGE, cfg_chain_in high and the card unconfigured. At offset host_addr[15:0] = 4i it returns the high nibble of identification byte i in rd_data[7:4]. At offset 4i+2 it returns the low nibble. Byte i is ID_BYTES[8i+7:8i]. rd_data updates on the clock edge that samples host_rd, and it holds its value between reads.
- R3: Byte 0 (offsets 0x00 and 0x02) is shown true, with rd_data[3:0] = 0. Bytes 1 to 15 are shown with the nibble inverted in [7:4] and rd_data[3:0] = 0xF.
- R4: A configuration read at an odd offset, or at any offset of 0x40 or above, returns 0xFF.
- R5: A configuration write is a write with host_wr high under the same conditions as a configuration read. A configuration write to offset 0x48 stores host_wdata as the window base (address bits 23:16) and configures the card. cfg_chain_out is 1 after that clock edge and stays 1 until reset.
- R6: A configuration write to offset 0x4C configures the card without mapping it. cfg_chain_out becomes 1 and win_hit then stays 0 for every address.
- R7: Once the card is mapped, win_hit is 1 in the same cycle as any access (host_rd or host_wr high) whose host_addr[23:16] equals the stored base. It is 0 for other addresses and when no strobe is active.
- R8: With cfg_chain_in low, or with host_addr[23:16] different from CFG_PAGE, reads return 0xFF and writes leave the card unconfigured.
- R9: After configuration the configuration page no longer responds. Reads there return 0xFF, and further writes to 0x48 or 0x4C change neither the base nor the state.
- R10: Configuration writes to offsets other than 0x48 and 0x4C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| cfg_chain_in | input | 1 | Chain enable from the previous card |
| rd_data | output | 8 | Registered read data |
| win_hit | output | 1 | Access falls in the mapped window |
| cfg_chain_out | output | 1 | Chain enable to the next card |

## Verification
A wrong configuration state shows at the ports within one cycle of the next access. A card that believes it is configured too early returns 0xFF instead of identification nibbles and raises cfg_chain_out. A card that never leaves the unconfigured state keeps answering configuration reads after the commit write and never asserts win_hit. A corrupted base register shows on the first probe of the window, because win_hit is combinational, fires on the wrong page, and stays silent on the assigned one. A wrong nibble presentation shows on the very next read, because each read lands in rd_data one edge after the strobe.

// File: rtl/acfg_pkg.sv
// Package: shared constants and the configuration state type.
// Assumes byte offsets within a 64 KB page are 16 bits wide.
package acfg_pkg;

    localparam logic [15:0] OFF_SET_BASE = 16'h0048;
    localparam logic [15:0] OFF_SHUT_UP  = 16'h004C;

    // Identification bytes, byte i at bits [8i+7:8i].
    localparam logic [127:0] ID_DEFAULT =
        128'h00000000_00800000_0000E107_00002AC1;

    typedef enum logic [1:0] {
        ST_UNCFG  = 2'd0,
        ST_MAPPED = 2'd1,
        ST_SHUT   = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/acfg_id_rom.sv
// Identification space: turns a page offset into the presented byte.
// Assumes the offset is already qualified as a configuration read.
// Byte 0 is presented true, all others inverted; empty slots read 0xFF.
module acfg_id_rom #(
    parameter int             N_BYTES = 16,
    parameter logic [127:0]   ID_VAL  = acfg_pkg::ID_DEFAULT
) (
    input  logic [15:0] off,
    output logic [7:0]  data
);
    localparam int          SPAN_I = N_BYTES * 4;
    localparam logic [15:0] SPAN   = 16'(SPAN_I);
    localparam int          OFS_W  = $clog2(SPAN_I);
    localparam int          IDX_W  = OFS_W - 2;

    logic [7:0] hi_view [N_BYTES];
    logic [7:0] lo_view [N_BYTES];

    // Build the presented form of each nibble at elaboration.
    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        if (g == 0) begin : g_true
            assign hi_view[g] = {ID_VAL[8*g+4 +: 4], 4'h0};
            assign lo_view[g] = {ID_VAL[8*g   +: 4], 4'h0};
        end else begin : g_inv
            assign hi_view[g] = {~ID_VAL[8*g+4 +: 4], 4'hF};
            assign lo_view[g] = {~ID_VAL[8*g   +: 4], 4'hF};
        end
    end

    logic [IDX_W-1:0] idx;
    assign idx = off[OFS_W-1:2];

    // Select the nibble slot or report an empty location.
    always_comb begin
        if (off >= SPAN || off[0])
            data = 8'hFF;
        else if (off[1])
            data = lo_view[idx];
        else
            data = hi_view[idx];
    end

endmodule

// File: rtl/acfg_cfg_ctrl.sv
// Configuration state holder: commits a base address or a shut-up.
// Assumes cfg_wr is a single-cycle write already qualified to the
// configuration page while unconfigured.
module acfg_cfg_ctrl
    import acfg_pkg::*;
#(
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       off,
    input  logic [BASE_W-1:0] wdata,
    output cfg_state_e        state,
    output logic [BASE_W-1:0] base,
    output logic              cfg_out
);
    // Advance the configuration state on a commit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_UNCFG;
            base  <= '0;
        end else if (state == ST_UNCFG && cfg_wr) begin
            if (off == OFF_SET_BASE) begin
                base  <= wdata;
                state <= ST_MAPPED;
            end else if (off == OFF_SHUT_UP) begin
                state <= ST_SHUT;
            end
        end
    end

    assign cfg_out = (state != ST_UNCFG);

    assert_chain_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out |=> cfg_out);

    assert_chain_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_out) |-> $past(cfg_wr));

    assert_base_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out |=> $stable(base));

endmodule

// File: rtl/acfg_win_decode.sv
// Window decoder: flags host accesses inside the mapped 64 KB page.
// Assumes strobes are one cycle wide; purely combinational.
module acfg_win_decode #(
    parameter int BASE_W = 8
) (
    input  logic [BASE_W-1:0] page,
    input  logic [BASE_W-1:0] base,
    input  logic              mapped,
    input  logic              rd,
    input  logic              wr,
    output logic              hit
);
    // Compare the page against the assigned base.
    always_comb begin
        hit = mapped && (rd || wr) && (page == base);
    end

endmodule

// File: rtl/acfg_responder.sv
// Top: configuration responder for one expansion card.
// Assumes a 24-bit byte address, 64 KB configuration page CFG_PAGE and
// single-cycle host strobes. Read data is registered.
module acfg_responder
    import acfg_pkg::*;
#(
    parameter int           ADDR_W   = 24,
    parameter int           N_BYTES  = 16,
    parameter logic [7:0]   CFG_PAGE = 8'hE8,
    parameter logic [127:0] ID_BYTES = ID_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              cfg_chain_in,
    output logic [7:0]        rd_data,
    output logic              win_hit,
    output logic              cfg_chain_out
);
    localparam int          PAGE_W = ADDR_W - 16;
    localparam logic [15:0] SPAN   = 16'(N_BYTES * 4);

    cfg_state_e         state;
    logic [PAGE_W-1:0]  base;
    logic [PAGE_W-1:0]  page;
    logic [15:0]        off;
    logic               cfg_sel;
    logic [7:0]         id_data;

    assign page = host_addr[ADDR_W-1:16];
    assign off  = host_addr[15:0];

    // Qualify accesses to the configuration page.
    always_comb begin
        cfg_sel = cfg_chain_in && (state == ST_UNCFG) && (page == PAGE_W'(CFG_PAGE));
    end

    acfg_id_rom #(.N_BYTES(N_BYTES), .ID_VAL(ID_BYTES)) id_rom_i (
        .off  (off),
        .data (id_data)
    );

    acfg_cfg_ctrl #(.BASE_W(PAGE_W)) cfg_ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (host_wr && cfg_sel),
        .off     (off),
        .wdata   (host_wdata[PAGE_W-1:0]),
        .state   (state),
        .base    (base),
        .cfg_out (cfg_chain_out)
    );

    acfg_win_decode #(.BASE_W(PAGE_W)) win_i (
        .page   (page),
        .base   (base),
        .mapped (state == ST_MAPPED),
        .rd     (host_rd),
        .wr     (host_wr),
        .hit    (win_hit)
    );

    // Capture read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 8'hFF;
        else if (host_rd)
            rd_data <= cfg_sel ? id_data : 8'hFF;
    end

    assert_rd_idle_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !cfg_sel) |=> (rd_data == 8'hFF));

    assert_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && cfg_sel && !off[0] && off < SPAN)
        |=> (rd_data[3:0] == 4'h0 || rd_data[3:0] == 4'hF));

    assert_shut_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHUT) |-> !win_hit);

endmodule

// File: tb/acfg_responder_tb.sv
// Bench for acfg_responder: table-driven identification reads, then
// directed configuration, window and reset cases.
module acfg_responder_tb_top;
    localparam int           CLK_PERIOD = 10;
    localparam logic [127:0] TB_ID = 128'h00000000_00800000_0000E107_00002AC1;
    localparam logic [7:0]   PAGE  = 8'hE8;
    localparam int           NV    = 12;
    localparam logic [15:0]  RD_OFFS [NV] = '{
        16'h0000, 16'h0002, 16'h0004, 16'h0006, 16'h0010, 16'h0012,
        16'h0014, 16'h0016, 16'h0028, 16'h0001, 16'h003E, 16'h0040 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        cfg_chain_in = 1'b0;
    logic [7:0]  rd_data;
    logic        win_hit;
    logic        cfg_chain_out;
    int          n_run = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acfg_responder #(.ID_BYTES(TB_ID), .CFG_PAGE(PAGE)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .cfg_chain_in(cfg_chain_in),
        .rd_data(rd_data), .win_hit(win_hit), .cfg_chain_out(cfg_chain_out));

    function automatic logic [7:0] model(input logic [15:0] o);
        logic [7:0] b;
        logic [3:0] nib;
        if (o >= 16'h0040 || o[0]) return 8'hFF;
        b   = TB_ID[8*o[5:2] +: 8];
        nib = o[1] ? b[3:0] : b[7:4];
        if (o[5:2] == 4'd0) return {nib, 4'h0};
        return {~nib, 4'hF};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_read(input logic [23:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
        v = rd_data;
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic probe(input logic [23:0] a, input logic strobe, output logic h);
        @(negedge clk);
        host_addr = a; host_rd = strobe;
        #1 h = win_hit;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        logic       h;
        do_reset();
        // R1: reset state
        chk("R1 rd_data", 32'(rd_data), 32'hFF);
        chk("R1 chain", 32'(cfg_chain_out), 0);
        probe(24'hE80000, 1'b1, h);
        chk("R1 win_hit", 32'(h), 0);

        cfg_chain_in = 1'b1;
        // R2 R3 R4: table of identification reads
        for (int k = 0; k < NV; k++) begin
            do_read({PAGE, RD_OFFS[k]}, v);
            if (RD_OFFS[k][0] || RD_OFFS[k] >= 16'h0040)
                chk("R4 empty slot", 32'(v), 32'(model(RD_OFFS[k])));
            else if (RD_OFFS[k][5:2] == 4'd0)
                chk("R2 true byte0", 32'(v), 32'(model(RD_OFFS[k])));
            else
                chk("R3 inverted byte", 32'(v), 32'(model(RD_OFFS[k])));
        end
        // R2: read data held between reads
        @(negedge clk); @(negedge clk);
        chk("R2 hold", 32'(rd_data), 32'(model(16'h0040)));

        // R8: chain input low ignores configuration traffic
        cfg_chain_in = 1'b0;
        do_read({PAGE, 16'h0000}, v);
        chk("R8 read chain low", 32'(v), 32'hFF);
        do_write({PAGE, 16'h0048}, 8'h20);
        chk("R8 write chain low", 32'(cfg_chain_out), 0);
        cfg_chain_in = 1'b1;
        // R8: wrong page
        do_read(24'hE90000, v);
        chk("R8 wrong page read", 32'(v), 32'hFF);
        do_write(24'hE90048, 8'h20);
        chk("R8 wrong page write", 32'(cfg_chain_out), 0);
        // R10: other offsets ignored, ID still readable
        do_write({PAGE, 16'h0050}, 8'h20);
        chk("R10 chain", 32'(cfg_chain_out), 0);
        do_read({PAGE, 16'h0004}, v);
        chk("R10 still unconfigured", 32'(v), 32'(model(16'h0004)));

        // R5: base write
        do_write({PAGE, 16'h0048}, 8'h20);
        chk("R5 chain out", 32'(cfg_chain_out), 1);
        // R7: window decode
        probe(24'h201234, 1'b1, h);
        chk("R7 hit in window", 32'(h), 1);
        probe(24'h210000, 1'b1, h);
        chk("R7 miss other page", 32'(h), 0);
        probe(24'h20FFFF, 1'b0, h);
        chk("R7 no strobe", 32'(h), 0);
        // R9: configuration page gone
        do_read({PAGE, 16'h0000}, v);
        chk("R9 read after cfg", 32'(v), 32'hFF);
        do_write({PAGE, 16'h0048}, 8'h30);
        probe(24'h300000, 1'b1, h);
        chk("R9 base not reloaded", 32'(h), 0);
        probe(24'h200000, 1'b1, h);
        chk("R9 base kept", 32'(h), 1);

        // R1 then R6: reset, then shut-up
        do_reset();
        chk("R1 chain after reset", 32'(cfg_chain_out), 0);
        probe(24'h200000, 1'b1, h);
        chk("R1 no hit after reset", 32'(h), 0);
        do_write({PAGE, 16'h004C}, 8'h20);
        chk("R6 chain out", 32'(cfg_chain_out), 1);
        probe(24'h000000, 1'b1, h);
        chk("R6 no hit page 0", 32'(h), 0);
        probe(24'h200000, 1'b1, h);
        chk("R6 no hit data page", 32'(h), 0);
        do_write({PAGE, 16'h0048}, 8'h40);
        probe(24'h400000, 1'b1, h);
        chk("R9 no map after shut-up", 32'(h), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule